// File: doc/BRIEF.md
# I2C Master Transfer-Count Sequencer

This block tracks how many bytes an I2C master still has to move in the current transaction and decides what happens when that number runs out. Software loads an 8-bit remaining-byte count. A byte-level bus engine pulses `byte_done` once per completed byte, and each pulse lowers the count by one. A single load covers at most 255 bytes. A longer transfer is split into chunks: with the chain flag set, the end of a chunk stretches the bus until software writes the next count. For example, 345 bytes go as a chunk of 255 followed by a chunk of 90.

The chain flag must be clear when the final chunk's count is loaded. Two policies then govern the end of that chunk. With automatic stop enabled, the block asks the engine for a STOP condition at once. Otherwise it raises a done flag, holds SCL low and can raise an interrupt. While the done flag is set, software picks either a STOP or a repeated START. Each request stays high until the engine acknowledges it.

Top module: `i2c_xfer_count_seq`

## Requirements
- R1: `cnt_wr` loads `cnt_wdata` into `remaining` on the next clock. Each `byte_done` pulse with a non-zero count lowers `remaining` by exactly one. A load in the same cycle as `byte_done` wins and takes no decrement.
- R2: When `remaining` is zero, `byte_done` has no effect: the count stays at zero and no flag or request changes.
- R3: With `chain_en` high, the `byte_done` that takes `remaining` from 1 to 0 sets `chain_wait` on the next clock, and `scl_hold` goes high with it.
- R4: A `cnt_wr` while `chain_wait` is set clears `chain_wait` on the next clock. `scl_hold` is released in the same clock, unless `xfer_done` is set.
- R5: With `chain_en` low and `auto_stop_en` high, the final `byte_done` raises `stop_req` on the next clock. `xfer_done` is not set.
- R6: With `chain_en` and `auto_stop_en` both low, the final `byte_done` sets `xfer_done` and `scl_hold` on the next clock. `irq` equals `irq_en` AND (`xfer_done` OR `chain_wait`).
- R7: While `xfer_done` is set, a `sw_stop` or `sw_restart` pulse raises `stop_req` or `restart_req` on the next clock, and in that same clock it clears `xfer_done` and releases `scl_hold`. If both pulses arrive together, only `stop_req` rises. A new request clears the other request line.
- R8: `sw_stop` and `sw_restart` pulses while `xfer_done` is low have no effect on any output.
- R9: `stop_req` and `restart_req` stay high until `eng_ack`, and drop on the clock after `eng_ack`.
- R10: While `rst_n` is low at a clock edge, `remaining`, every flag, both requests and `scl_hold` go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_wr | input | 1 | Load strobe for the byte count |
| cnt_wdata | input | 8 | Byte count to load |
| chain_en | input | 1 | Chunk-chaining (reload) enable |
| auto_stop_en | input | 1 | Automatic STOP at end of count |
| irq_en | input | 1 | Interrupt enable |
| sw_stop | input | 1 | Software STOP command pulse |
| sw_restart | input | 1 | Software repeated-START command pulse |
| byte_done | input | 1 | Engine pulse: one byte transferred |
| eng_ack | input | 1 | Engine accepts the pending request |
| remaining | output | 8 | Bytes left in the current chunk |
| chain_wait | output | 1 | Chunk finished, waiting for a new count |
| xfer_done | output | 1 | Final chunk finished, waiting for a command |
| scl_hold | output | 1 | Request to hold SCL low |
| stop_req | output | 1 | STOP request to the engine |
| restart_req | output | 1 | Repeated-START request to the engine |
| irq | output | 1 | Interrupt |

## Verification
The hardest situation to reach is a full 255-byte chunk followed by a short final chunk. The bench has to let the count drain all the way through its top value, wait at the stall, switch off chaining and then load the tail count, in that order. A directed sequence drives exactly that 255-plus-90 split. Around it, it places collisions: a load in the same cycle as a byte, both commands in one cycle, and commands while nothing is finished. A random phase then mixes these pulses. A behavioural model is compared with every output on every clock.

// File: rtl/i2c_xfer_pkg.sv
package i2c_xfer_pkg;
    // Width of the per-chunk byte count
    parameter int CNT_W = 8;
    // Kind of end-of-count action selected by the policy
    typedef enum logic [1:0] {
        EOC_NONE  = 2'd0,
        EOC_CHAIN = 2'd1,
        EOC_STOP  = 2'd2,
        EOC_WAIT  = 2'd3
    } eoc_kind_e;
endpackage

// File: rtl/xfer_down_counter.sv
// Remaining-byte counter.
// Loads on ld, decrements on dec, saturates at zero. Asserts last_hit for
// the single cycle in which a decrement takes the count from 1 to 0.
// Assumes dec is a one-cycle pulse per byte.
module xfer_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         last_hit
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    // Final-byte detection: only a real decrement from one counts
    assign last_hit = dec && !ld && (cnt == ONE);

    // Count register: load wins, otherwise decrement when non-zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= ZERO;
        else if (ld)
            cnt <= ld_val;
        else if (dec && (cnt != ZERO))
            cnt <= cnt - ONE;
    end

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !ld && cnt != ZERO) |=> (cnt == $past(cnt) - ONE)); // R1
    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && cnt == ZERO) |=> (cnt == ZERO)); // R2
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val))); // R1
endmodule

// File: rtl/xfer_eoc_policy.sv
// End-of-count policy.
// Chooses what the final byte of a chunk does: stall for a new count
// (chaining), request an automatic STOP, or park in the done state.
// Also keeps the two waiting flags. Assumes the load and the final byte
// never coincide (the counter guarantees it).
module xfer_eoc_policy
    import i2c_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic last_hit,
    input  logic chain_en,
    input  logic auto_stop_en,
    input  logic ld,
    input  logic cmd_taken,
    output logic auto_stop,
    output logic chain_wait,
    output logic xfer_done
);
    eoc_kind_e kind;

    // Classify the end-of-count event against the current configuration
    always_comb begin
        if (!last_hit)
            kind = EOC_NONE;
        else if (chain_en)
            kind = EOC_CHAIN;
        else if (auto_stop_en)
            kind = EOC_STOP;
        else
            kind = EOC_WAIT;
    end

    assign auto_stop = (kind == EOC_STOP);

    // Chain-wait flag: set at chunk end, cleared by a new count
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_wait <= 1'b0;
        else if (ld)
            chain_wait <= 1'b0;
        else if (kind == EOC_CHAIN)
            chain_wait <= 1'b1;
    end

    // Done flag: set at final chunk end, cleared once a command is taken
    always_ff @(posedge clk) begin
        if (!rst_n)
            xfer_done <= 1'b0;
        else if (cmd_taken)
            xfer_done <= 1'b0;
        else if (kind == EOC_WAIT)
            xfer_done <= 1'b1;
    end

    AST_CHAIN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_wait) |-> $past(chain_en)); // R3
    AST_LOAD_CLEARS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> !chain_wait); // R4
    AST_DONE_NOT_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> !$past(auto_stop_en)); // R5
endmodule

// File: rtl/xfer_cmd_req.sv
// Engine request holder.
// Raises STOP or repeated-START requests from the automatic policy or from
// software commands, holding each until the engine acknowledges. A new
// request replaces the other kind; STOP beats RESTART in the same cycle.
// Software commands count only while the done flag is set.
module xfer_cmd_req (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_stop,
    input  logic sw_stop,
    input  logic sw_restart,
    input  logic done_flag,
    input  logic eng_ack,
    output logic cmd_taken,
    output logic stop_req,
    output logic restart_req
);
    logic set_stop;
    logic set_restart;

    // Decode which request, if any, starts this cycle
    always_comb begin
        cmd_taken   = done_flag && (sw_stop || sw_restart);
        set_stop    = auto_stop || (cmd_taken && sw_stop);
        set_restart = cmd_taken && !sw_stop && !auto_stop;
    end

    // Request registers: set wins over acknowledge, newest kind replaces other
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_req    <= 1'b0;
            restart_req <= 1'b0;
        end else if (set_stop) begin
            stop_req    <= 1'b1;
            restart_req <= 1'b0;
        end else if (set_restart) begin
            stop_req    <= 1'b0;
            restart_req <= 1'b1;
        end else if (eng_ack) begin
            stop_req    <= 1'b0;
            restart_req <= 1'b0;
        end
    end

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_req && restart_req)); // R7
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && sw_stop && sw_restart) |=> (stop_req && !restart_req)); // R7
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !eng_ack) |=> stop_req); // R9
    AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_req && !eng_ack && !set_stop) |=> restart_req); // R9
    AST_NO_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_flag && !auto_stop && !stop_req && !restart_req) |=> (!stop_req && !restart_req)); // R8
endmodule

// File: rtl/i2c_xfer_count_seq.sv
// I2C master transfer-count sequencer (top).
// Counts bytes reported by the bus engine, stalls between chained chunks,
// and applies the end-of-count policy (automatic STOP or wait for a
// software STOP/RESTART). Assumes byte_done is a single-cycle pulse and
// that the engine does not report bytes while SCL is held.
module i2c_xfer_count_seq
    import i2c_xfer_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          chain_en,
    input  logic          auto_stop_en,
    input  logic          irq_en,
    input  logic          sw_stop,
    input  logic          sw_restart,
    input  logic          byte_done,
    input  logic          eng_ack,
    output logic [CW-1:0] remaining,
    output logic          chain_wait,
    output logic          xfer_done,
    output logic          scl_hold,
    output logic          stop_req,
    output logic          restart_req,
    output logic          irq
);
    logic last_hit;
    logic auto_stop;
    logic cmd_taken;

    xfer_down_counter #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (cnt_wr),
        .ld_val   (cnt_wdata),
        .dec      (byte_done),
        .cnt      (remaining),
        .last_hit (last_hit)
    );

    xfer_eoc_policy u_pol (
        .clk          (clk),
        .rst_n        (rst_n),
        .last_hit     (last_hit),
        .chain_en     (chain_en),
        .auto_stop_en (auto_stop_en),
        .ld           (cnt_wr),
        .cmd_taken    (cmd_taken),
        .auto_stop    (auto_stop),
        .chain_wait   (chain_wait),
        .xfer_done    (xfer_done)
    );

    xfer_cmd_req u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_stop   (auto_stop),
        .sw_stop     (sw_stop),
        .sw_restart  (sw_restart),
        .done_flag   (xfer_done),
        .eng_ack     (eng_ack),
        .cmd_taken   (cmd_taken),
        .stop_req    (stop_req),
        .restart_req (restart_req)
    );

    // Clock stretch and interrupt follow the two waiting flags
    always_comb begin
        scl_hold = chain_wait || xfer_done;
        irq      = irq_en && (chain_wait || xfer_done);
    end

    AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        chain_wait |-> scl_hold); // R3
    AST_HOLD_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> scl_hold); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R6
    AST_CMD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && (sw_stop || sw_restart)) |=> !xfer_done); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (remaining == '0 && !chain_wait && !xfer_done && !stop_req && !restart_req)); // R10
endmodule

// File: tb/tb_i2c_xfer_count_seq.sv
module tb_i2c_xfer_count_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = 8'd0;
    logic       chain_en = 1'b0;
    logic       auto_stop_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       sw_stop = 1'b0;
    logic       sw_restart = 1'b0;
    logic       byte_done = 1'b0;
    logic       eng_ack = 1'b0;
    logic [7:0] remaining;
    logic       chain_wait, xfer_done, scl_hold, stop_req, restart_req, irq;

    i2c_xfer_count_seq dut (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .chain_en(chain_en), .auto_stop_en(auto_stop_en), .irq_en(irq_en),
        .sw_stop(sw_stop), .sw_restart(sw_restart), .byte_done(byte_done),
        .eng_ack(eng_ack), .remaining(remaining), .chain_wait(chain_wait),
        .xfer_done(xfer_done), .scl_hold(scl_hold), .stop_req(stop_req),
        .restart_req(restart_req), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    bit    checking = 1'b0;
    string cur_req = "R10";

    // Behavioural reference state
    int m_cnt = 0;
    int m_wait = 0;
    int m_done = 0;
    int m_stop = 0;
    int m_rst = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_wait = 0; m_done = 0; m_stop = 0; m_rst = 0;
        end else begin
            bit last, take;
            last = byte_done && !cnt_wr && (m_cnt == 1);
            take = (m_done == 1) && (sw_stop || sw_restart);
            if (last && !chain_en && auto_stop_en) begin
                m_stop = 1; m_rst = 0;
            end else if (take && sw_stop) begin
                m_stop = 1; m_rst = 0;
            end else if (take) begin
                m_stop = 0; m_rst = 1;
            end else if (eng_ack) begin
                m_stop = 0; m_rst = 0;
            end
            if (cnt_wr) m_wait = 0;
            else if (last && chain_en) m_wait = 1;
            if (take) m_done = 0;
            else if (last && !chain_en && !auto_stop_en) m_done = 1;
            if (cnt_wr) m_cnt = cnt_wdata;
            else if (byte_done && m_cnt > 0) m_cnt = m_cnt - 1;
        end
    end

    task automatic cmp(string name, int act, int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, name, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            int hold_e, irq_e;
            hold_e = (m_wait | m_done);
            irq_e  = irq_en ? hold_e : 0;
            vectors++;
            cmp("remaining", int'(remaining), m_cnt);
            cmp("chain_wait", int'(chain_wait), m_wait);
            cmp("xfer_done", int'(xfer_done), m_done);
            cmp("scl_hold", int'(scl_hold), hold_e);
            cmp("stop_req", int'(stop_req), m_stop);
            cmp("restart_req", int'(restart_req), m_rst);
            cmp("irq", int'(irq), irq_e);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            cnt_wr = 0; byte_done = 0; sw_stop = 0; sw_restart = 0; eng_ack = 0;
        end
    endtask

    task automatic load(int v);
        cnt_wr = 1; cnt_wdata = 8'(v); step();
    endtask

    task automatic bytes(int n);
        for (int i = 0; i < n; i++) begin
            byte_done = 1; step();
        end
    endtask

    task automatic ack();
        eng_ack = 1; step();
    endtask

    initial begin
        // R10: reset state
        cur_req = "R10";
        step(2);
        checking = 1'b1;
        step(2);
        rst_n = 1'b1;
        #1;

        // R1: load, decrement, load beats byte in the same cycle
        cur_req = "R1";
        load(5);
        bytes(2);
        cnt_wr = 1; cnt_wdata = 8'd9; byte_done = 1; step();
        bytes(3);
        step(2);

        // R8: commands while nothing finished
        cur_req = "R8";
        sw_stop = 1; step();
        sw_restart = 1; step();
        sw_stop = 1; sw_restart = 1; step();

        // R2: zero count ignores bytes
        cur_req = "R2";
        load(0);
        bytes(3);
        step(2);

        // R5 / R9: automatic stop, held until ack
        cur_req = "R5";
        auto_stop_en = 1;
        load(3);
        bytes(3);
        cur_req = "R9";
        step(3);
        ack();
        step(2);

        // R3 / R4 / R6: 345 bytes as 255 + 90 with software end
        cur_req = "R3";
        auto_stop_en = 0; chain_en = 1; irq_en = 1;
        load(255);
        bytes(255);
        step(4);
        cur_req = "R4";
        chain_en = 0;
        load(90);
        bytes(90);
        cur_req = "R6";
        step(3);
        irq_en = 0; step(2);
        irq_en = 1; step();

        // R7: both commands together, stop wins
        cur_req = "R7";
        sw_stop = 1; sw_restart = 1; step();
        step(2);
        cur_req = "R9";
        ack(); step();

        // R7: restart alone
        cur_req = "R7";
        load(2);
        bytes(2);
        sw_restart = 1; step();
        step(2);
        ack(); step();

        // R4: new count while chain wait also releases hold
        cur_req = "R4";
        chain_en = 1;
        load(1);
        bytes(1);
        step(2);
        load(4);
        step();

        // Mixed random pulses, all requirements against the model
        cur_req = "R1";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 8) begin
                cnt_wr = 1; cnt_wdata = 8'($urandom_range(0, 6));
            end
            byte_done    = ($urandom_range(0, 99) < 45);
            sw_stop      = ($urandom_range(0, 99) < 10);
            sw_restart   = ($urandom_range(0, 99) < 10);
            eng_ack      = ($urandom_range(0, 99) < 20);
            if (r > 95) chain_en = ~chain_en;
            if (r == 50) auto_stop_en = ~auto_stop_en;
            if (r == 51) irq_en = ~irq_en;
            step();
        end

        // R10: reset mid-operation
        cur_req = "R10";
        load(3);
        rst_n = 0; step(2);
        rst_n = 1; step(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule